// File: doc/BRIEF.md
# Bit-Addressable Peripheral Register Space

This block holds the peripheral control and status registers of a small microcontroller core. The core reaches every register along two routes. The port route takes an I/O index directly. The memory route takes a data-space address and subtracts a fixed offset to find the same register. Both routes read and write whole registers.

The lower window of the space also accepts single-bit operations: set a bit, clear a bit, or test a bit so that the core can decide whether to skip. Status registers hold flags that peripherals raise through hardware set lines. Software clears a flag by writing a one to it. A bit set or clear is carried out as a read-modify-write of the whole register, so it also clears every other flag that reads as set. This is deliberate and visible behaviour. A bit operation outside the window changes nothing and raises a one-cycle error pulse.

Register layout, by the low three bits of the I/O index (the slot):
- Slot 7 is a reserved address.
- Slot 6 implements only bits 3:0.
- Slot 5 is a status register. Bits 7:4 are write-one-to-clear flags and bits 3:0 are plain.
- Every other slot is a full 8-bit plain register.

Top module: `bitio_regspace`

## Requirements
- R1: Port-route operations (read op 1, write op 2) reach register index `addr` for addr 0x00..0x3F. A port write at addr 0x40 or above changes no register, and a port read there returns 0x00.
- R2: Memory-route operations (read op 3, write op 4) at addr 0x20..0x5F reach register index addr-0x20. Outside that range a memory write changes nothing and a memory read returns 0x00.
- R3: Bit set (op 5) and bit clear (op 6) at index 0x00..0x1F force bit `bit_sel` to 1 or to 0. The plain bits the operation does not target keep their values.
- R4: Bit test (op 7) returns bit `bit_sel` of the register on `test_bit` for index 0x00..0x1F. It returns 0 for any other address.
- R5: A bit operation (op 5, 6 or 7) with addr 0x20 or above changes no register. It drives `bit_err` high for exactly the following cycle. Any other operation leaves `bit_err` low in the next cycle.
- R6: In a status register (slot 5), a whole-register write clears each flag in bits 7:4 whose written bit is 1 and keeps each flag whose written bit is 0. Bits 3:0 take the written value.
- R7: A bit set or clear on a status register writes the whole modified value back. Every flag that read as 1 and is 1 in the modified value gets cleared. As a result, a bit clear of a set flag keeps that flag and clears the other set flags.
- R8: `hw_set[4g+k]` sets flag bit 4+k of the status register at index 8g+5 on the next edge. When a write clears the same flag in the same cycle, the set wins.
- R9: Reserved bits (slot 6 bits 7:4, all of slot 7) always read as 0. A write to slot 7 changes no register.
- R10: Reads are combinational in the cycle of the request. Writes take effect at the next rising edge. A synchronous `rst` clears every register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 3 | Operation: 0 none, 1 port read, 2 port write, 3 memory read, 4 memory write, 5 bit set, 6 bit clear, 7 bit test |
| addr | input | 7 | I/O index for ops 1, 2, 5, 6, 7; data-space address for ops 3, 4 |
| wdata | input | 8 | Write data for ops 2 and 4 |
| bit_sel | input | 3 | Bit number for ops 5, 6, 7 |
| hw_set | input | 32 | Flag set lines, four per status register |
| rdata | output | 8 | Read data for ops 1 and 3, else 0 |
| test_bit | output | 1 | Selected bit for op 7 inside the window, else 0 |
| bit_err | output | 1 | One-cycle pulse after a bit operation outside the window |

## Verification
The hardest case to reach is a flag being set and cleared in the same cycle, because the hardware set and the software clear come from independent sides. The stimulus first builds a known flag pattern through `hw_set`. It then drives a one-to-clear write on the core bus with `hw_set` asserted on the same flag in the same cycle. Separate sequences rebuild the flags before each bit set and bit clear on a status register. This shows which flags the read-modify-write sweeps away.

// File: rtl/bitio_pkg.sv
package bitio_pkg;

    localparam int DW       = 8;
    localparam int FLAG_W   = DW / 2;
    localparam int SLOT_W   = 3;
    localparam int GRP_SIZE = 2 ** SLOT_W;

    localparam logic [SLOT_W-1:0] SLOT_STAT = 3'd5;
    localparam logic [SLOT_W-1:0] SLOT_HALF = 3'd6;
    localparam logic [SLOT_W-1:0] SLOT_RSV  = 3'd7;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_IO_RD  = 3'd1,
        OP_IO_WR  = 3'd2,
        OP_MEM_RD = 3'd3,
        OP_MEM_WR = 3'd4,
        OP_BSET   = 3'd5,
        OP_BCLR   = 3'd6,
        OP_BTST   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        WM_WORD = 2'd0,
        WM_SET  = 2'd1,
        WM_CLR  = 2'd2
    } wmode_e;

    // bits that hold state in a register of the given slot
    function automatic logic [DW-1:0] impl_mask(input logic [SLOT_W-1:0] slot);
        if (slot == SLOT_RSV)       return '0;
        else if (slot == SLOT_HALF) return {{(DW-FLAG_W){1'b0}}, {FLAG_W{1'b1}}};
        else                        return '1;
    endfunction

    // write-one-to-clear flag bits of the given slot
    function automatic logic [DW-1:0] w1c_mask(input logic [SLOT_W-1:0] slot);
        if (slot == SLOT_STAT) return {{FLAG_W{1'b1}}, {(DW-FLAG_W){1'b0}}};
        else                   return '0;
    endfunction

endpackage

// File: rtl/bitio_addr_dec.sv
module bitio_addr_dec
    import bitio_pkg::*;
#(
    parameter int IO_AW     = 6,
    parameter int BUS_AW    = 7,
    parameter int DS_OFFSET = 32,
    parameter int WIN_AW    = 5
) (
    input  op_e               op,
    input  logic [BUS_AW-1:0] addr,
    output logic [IO_AW-1:0]  idx,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic              tst_hit,
    output logic              bad_bit,
    output wmode_e            wmode
);
    localparam int IO_WORDS = 2 ** IO_AW;
    localparam int WIDE     = BUS_AW + 1;

    logic [WIDE-1:0]   a_w;
    logic [BUS_AW-1:0] mem_rel;
    logic              io_in;
    logic              mem_in;
    logic              win_in;

    assign a_w     = {1'b0, addr};
    assign mem_rel = addr - BUS_AW'(DS_OFFSET);
    assign io_in   = a_w < WIDE'(IO_WORDS);
    assign mem_in  = (a_w >= WIDE'(DS_OFFSET)) && (a_w < WIDE'(DS_OFFSET + IO_WORDS));
    assign win_in  = a_w < WIDE'(2 ** WIN_AW);

    always_comb begin
        idx     = addr[IO_AW-1:0];
        rd_hit  = 1'b0;
        wr_hit  = 1'b0;
        tst_hit = 1'b0;
        bad_bit = 1'b0;
        wmode   = WM_WORD;
        unique case (op)
            OP_IO_RD:  rd_hit = io_in;
            OP_IO_WR:  wr_hit = io_in;
            OP_MEM_RD: begin
                idx    = mem_rel[IO_AW-1:0];
                rd_hit = mem_in;
            end
            OP_MEM_WR: begin
                idx    = mem_rel[IO_AW-1:0];
                wr_hit = mem_in;
            end
            OP_BSET: begin
                wr_hit  = win_in;
                bad_bit = !win_in;
                wmode   = WM_SET;
            end
            OP_BCLR: begin
                wr_hit  = win_in;
                bad_bit = !win_in;
                wmode   = WM_CLR;
            end
            OP_BTST: begin
                tst_hit = win_in;
                bad_bit = !win_in;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bitio_merge.sv
module bitio_merge
    import bitio_pkg::*;
(
    input  logic [DW-1:0]     cur,
    input  logic [DW-1:0]     wdata,
    input  logic [2:0]        bit_sel,
    input  wmode_e            wmode,
    input  logic [SLOT_W-1:0] slot,
    output logic [DW-1:0]     nxt
);
    logic [DW-1:0] src;
    logic [DW-1:0] onehot;
    logic [DW-1:0] plain_m;
    logic [DW-1:0] flag_m;

    assign onehot  = DW'(1) << bit_sel;
    assign flag_m  = w1c_mask(slot);
    assign plain_m = impl_mask(slot) & ~flag_m;

    always_comb begin
        unique case (wmode)
            WM_SET:  src = cur | onehot;
            WM_CLR:  src = cur & ~onehot;
            default: src = wdata;
        endcase
        // plain bits take the source, flags survive only where the source holds 0
        nxt = (src & plain_m) | (cur & flag_m & ~src);
    end
endmodule

// File: rtl/bitio_regspace.sv
module bitio_regspace
    import bitio_pkg::*;
#(
    parameter int IO_AW     = 6,
    parameter int BUS_AW    = 7,
    parameter int DS_OFFSET = 32,
    parameter int WIN_AW    = 5,
    localparam int IO_WORDS = 2 ** IO_AW,
    localparam int GROUPS   = IO_WORDS / GRP_SIZE,
    localparam int HW_W     = GROUPS * FLAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [2:0]        bit_sel,
    input  logic [HW_W-1:0]   hw_set,
    output logic [DW-1:0]     rdata,
    output logic              test_bit,
    output logic              bit_err
);
    typedef struct packed {
        logic [IO_WORDS-1:0][DW-1:0] regs;
        logic                        err;
    } state_t;

    state_t state_d, state_q;

    logic [IO_WORDS-1:0][DW-1:0] regs_q;
    logic [IO_WORDS-1:0][DW-1:0] set_vec;
    logic [IO_AW-1:0]            idx;
    logic                        rd_hit, wr_hit, tst_hit, bad_bit;
    wmode_e                      wmode;
    logic [DW-1:0]               cur, merged;

    assign regs_q = state_q.regs;

    bitio_addr_dec #(
        .IO_AW(IO_AW), .BUS_AW(BUS_AW), .DS_OFFSET(DS_OFFSET), .WIN_AW(WIN_AW)
    ) i_dec (
        .op(op), .addr(addr), .idx(idx), .rd_hit(rd_hit), .wr_hit(wr_hit),
        .tst_hit(tst_hit), .bad_bit(bad_bit), .wmode(wmode)
    );

    assign cur = regs_q[idx];

    bitio_merge i_merge (
        .cur(cur), .wdata(wdata), .bit_sel(bit_sel), .wmode(wmode),
        .slot(idx[SLOT_W-1:0]), .nxt(merged)
    );

    // route each group's set lines onto the flag half of its status register
    for (genvar i = 0; i < IO_WORDS; i++) begin : g_set
        if ((i % GRP_SIZE) == int'(SLOT_STAT)) begin : g_stat
            assign set_vec[i] = {hw_set[(i / GRP_SIZE) * FLAG_W +: FLAG_W], {(DW-FLAG_W){1'b0}}};
        end else begin : g_plain
            assign set_vec[i] = '0;
        end
    end

    always_comb begin
        state_d     = state_q;
        state_d.err = bad_bit;
        if (wr_hit) begin
            state_d.regs[idx] = merged;
        end
        // set lines applied last so a same-cycle clear loses
        state_d.regs = state_d.regs | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign rdata    = rd_hit  ? cur          : '0;
    assign test_bit = tst_hit ? cur[bit_sel] : 1'b0;
    assign bit_err  = state_q.err;
endmodule

// File: rtl/bitio_regspace_chk.sv
module bitio_regspace_chk
    import bitio_pkg::*;
#(
    parameter int IO_AW  = 6,
    parameter int BUS_AW = 7,
    parameter int WIN_AW = 5,
    localparam int IO_WORDS = 2 ** IO_AW,
    localparam int GROUPS   = IO_WORDS / GRP_SIZE,
    localparam int HW_W     = GROUPS * FLAG_W
) (
    input logic                        clk,
    input logic                        rst,
    input op_e                         op,
    input logic [BUS_AW-1:0]           addr,
    input logic [HW_W-1:0]             hw_set,
    input logic                        test_bit,
    input logic                        bit_err,
    input logic [IO_WORDS-1:0][DW-1:0] regs_q
);
    logic [HW_W-1:0] flags;
    logic            is_bitop;
    logic            out_win;

    for (genvar g = 0; g < GROUPS; g++) begin : g_fl
        assign flags[g*FLAG_W +: FLAG_W] = regs_q[g*GRP_SIZE + int'(SLOT_STAT)][DW-1 -: FLAG_W];
    end

    assign is_bitop = (op == OP_BSET) || (op == OP_BCLR) || (op == OP_BTST);
    assign out_win  = {1'b0, addr} >= (BUS_AW+1)'(2 ** WIN_AW);

    // R10
    reset_clear_chk: assert property (@(posedge clk) rst |=> (regs_q == '0));

    // R8
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    // R5
    bad_bitop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (is_bitop && out_win) |=> bit_err);

    // R5
    no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !(is_bitop && out_win) |=> !bit_err);

    // R5
    bad_bitop_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (is_bitop && out_win && hw_set == '0) |=> $stable(regs_q));

    // R9
    rsv_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IO_WR && addr[SLOT_W-1:0] == SLOT_RSV && hw_set == '0) |=> $stable(regs_q));

    // R4
    test_out_window_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BTST && out_win) |-> !test_bit);

    for (genvar i = 0; i < IO_WORDS; i++) begin : g_rsv
        // R9
        rsv_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (regs_q[i] & ~impl_mask(SLOT_W'(i))) == '0);
    end
endmodule

bind bitio_regspace bitio_regspace_chk #(
    .IO_AW(IO_AW), .BUS_AW(BUS_AW), .WIN_AW(WIN_AW)
) i_chk (
    .clk(clk), .rst(rst), .op(op), .addr(addr), .hw_set(hw_set),
    .test_bit(test_bit), .bit_err(bit_err), .regs_q(regs_q)
);

// File: tb/test_bitio_regspace.sv
module test_bitio_regspace;
    import bitio_pkg::*;

    typedef struct packed {
        logic [23:0] tag;
        logic [2:0]  op;
        logic [6:0]  addr;
        logic [7:0]  wd;
        logic [2:0]  bs;
        logic [7:0]  rd;
        logic        tb;
        logic        er;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{"R1 ", 3'd2, 7'h03, 8'hA5, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R1 ", 3'd1, 7'h03, 8'h00, 3'd0, 8'hA5, 1'b0, 1'b0},
        '{"R2 ", 3'd3, 7'h23, 8'h00, 3'd0, 8'hA5, 1'b0, 1'b0},
        '{"R2 ", 3'd4, 7'h5E, 8'h3C, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R9 ", 3'd1, 7'h3E, 8'h00, 3'd0, 8'h0C, 1'b0, 1'b0},
        '{"R2 ", 3'd4, 7'h10, 8'hFF, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R2 ", 3'd1, 7'h10, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R9 ", 3'd2, 7'h0F, 8'hFF, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R9 ", 3'd1, 7'h0F, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R3 ", 3'd5, 7'h03, 8'h00, 3'd1, 8'h00, 1'b0, 1'b0},
        '{"R3 ", 3'd1, 7'h03, 8'h00, 3'd0, 8'hA7, 1'b0, 1'b0},
        '{"R3 ", 3'd6, 7'h03, 8'h00, 3'd7, 8'h00, 1'b0, 1'b0},
        '{"R3 ", 3'd1, 7'h03, 8'h00, 3'd0, 8'h27, 1'b0, 1'b0},
        '{"R4 ", 3'd7, 7'h03, 8'h00, 3'd5, 8'h00, 1'b1, 1'b0},
        '{"R4 ", 3'd7, 7'h03, 8'h00, 3'd3, 8'h00, 1'b0, 1'b0},
        '{"R5 ", 3'd5, 7'h23, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1},
        '{"R5 ", 3'd1, 7'h23, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R5 ", 3'd7, 7'h30, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1},
        '{"R1 ", 3'd2, 7'h22, 8'h5A, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R5 ", 3'd6, 7'h22, 8'h00, 3'd1, 8'h00, 1'b0, 1'b1},
        '{"R5 ", 3'd1, 7'h22, 8'h00, 3'd0, 8'h5A, 1'b0, 1'b0},
        '{"R1 ", 3'd2, 7'h40, 8'hFF, 3'd0, 8'h00, 1'b0, 1'b0},
        '{"R1 ", 3'd1, 7'h00, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    op_e         op = OP_NONE;
    logic [6:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  bit_sel = '0;
    logic [31:0] hw_set = '0;
    logic [7:0]  rdata;
    logic        test_bit;
    logic        bit_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bitio_regspace i_bitio_regspace (
        .clk(clk), .rst(rst), .op(op), .addr(addr), .wdata(wdata),
        .bit_sel(bit_sel), .hw_set(hw_set), .rdata(rdata),
        .test_bit(test_bit), .bit_err(bit_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at falling edge, leave one time unit for combinational outputs
    task automatic drive(input logic [2:0] o, input logic [6:0] a, input logic [7:0] d,
                         input logic [2:0] b, input logic [31:0] h);
        @(negedge clk);
        op      = op_e'(o);
        addr    = a;
        wdata   = d;
        bit_sel = b;
        hw_set  = h;
        #1;
    endtask

    task automatic edge_pass;
        @(posedge clk);
        #1;
    endtask

    task automatic read_io(input string req, input logic [6:0] a, input logic [7:0] exp);
        drive(3'd1, a, 8'h00, 3'd0, 32'h0);
        check(req, 32'(rdata), 32'(exp));
        edge_pass();
    endtask

    task automatic apply(input logic [2:0] o, input logic [6:0] a, input logic [7:0] d,
                         input logic [2:0] b, input logic [31:0] h);
        drive(o, a, d, b, h);
        edge_pass();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R10 reset state and synchronous clear
        read_io("R10", 7'h03, 8'h00);
        read_io("R10", 7'h3C, 8'h00);
        check("R10", 32'(bit_err), 32'h0);
        apply(3'd2, 7'h03, 8'h77, 3'd0, 32'h0);
        read_io("R10", 7'h03, 8'h77);
        @(negedge clk);
        rst = 1'b1;
        edge_pass();
        @(negedge clk);
        rst = 1'b0;
        read_io("R10", 7'h03, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].addr, VEC[i].wd, VEC[i].bs, 32'h0);
            check(string'(VEC[i].tag), 32'(rdata), 32'(VEC[i].rd));
            check(string'(VEC[i].tag), 32'(test_bit), 32'(VEC[i].tb));
            edge_pass();
            check(string'(VEC[i].tag), 32'(bit_err), 32'(VEC[i].er));
        end
        drive(3'd3, 7'h63, 8'h00, 3'd0, 32'h0);
        check("R2", 32'(rdata), 32'h0);
        edge_pass();

        // R8 flags raised by hardware in status register 0x05
        apply(3'd0, 7'h00, 8'h00, 3'd0, 32'h0000_000B);
        read_io("R8", 7'h05, 8'hB0);
        // R6 zero-written flags kept, plain bits written
        apply(3'd2, 7'h05, 8'h06, 3'd0, 32'h0);
        read_io("R6", 7'h05, 8'hB6);
        // R6 one-written flag cleared
        apply(3'd2, 7'h05, 8'h16, 3'd0, 32'h0);
        read_io("R6", 7'h05, 8'hA6);
        // R7 bit set sweeps every set flag
        apply(3'd5, 7'h05, 8'h00, 3'd0, 32'h0);
        read_io("R7", 7'h05, 8'h07);
        // R7 bit clear of a set flag keeps it, clears the others
        apply(3'd0, 7'h00, 8'h00, 3'd0, 32'h0000_000F);
        read_io("R8", 7'h05, 8'hF7);
        apply(3'd6, 7'h05, 8'h00, 3'd5, 32'h0);
        read_io("R7", 7'h05, 8'h27);
        // R8 set and clear of the same flag in one cycle: set wins
        apply(3'd2, 7'h05, 8'h27, 3'd0, 32'h0000_0002);
        read_io("R8", 7'h05, 8'h27);
        // R8 top group mapping through the memory route
        apply(3'd0, 7'h00, 8'h00, 3'd0, 32'hF000_0000);
        drive(3'd3, 7'h5D, 8'h00, 3'd0, 32'h0);
        check("R8", 32'(rdata), 32'hF0);
        edge_pass();
        // R4 bit test of a flag
        drive(3'd7, 7'h05, 8'h00, 3'd5, 32'h0);
        check("R4", 32'(test_bit), 32'h1);
        edge_pass();
        check("R5", 32'(bit_err), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule